// File: doc/BRIEF.md
# Clock Divider Alignment Sequencer

This block brings a group of regional clock dividers into a common phase. All of the dividers are fed through one gating buffer from a shared fast clock. The sequencer runs on that ungated input clock. It closes the gate, clears every divider together, releases the clear, and only then reopens the gate. Each divider therefore restarts from its reset count on the same gated edge.

Each step lasts `WAIT_CYC` input-clock cycles. One down-counter times all of the steps and is reloaded whenever the state changes. When reset is released the block is already in the clear step, so it completes the alignment without a request. Afterwards it idles with the gate open and `done_o` high. A start request sampled while idle runs the whole sequence again. The enable, clear and done outputs each come straight from a flip-flop, which keeps the decode shallow enough for input clocks of several hundred MHz.

Top module: `clkdiv_align_seq`

## Requirements
- R1: While `rst_n` is sampled low, `clk_en_o` is 0, `div_clr_o` is 1 and `done_o` is 0.
- R2: After reset is released, with no start request, `div_clr_o` falls at the `WAIT_CYC`-th clock edge and `clk_en_o` rises at edge 2·`WAIT_CYC`.
- R3: `done_o` rises on the clock edge after the one on which `clk_en_o` rises. It stays high until a start request is sampled or reset is applied.
- R4: When `start_req` is sampled high while idle, `clk_en_o` and `done_o` both fall on that same edge.
- R5: `div_clr_o` rises `WAIT_CYC` edges after the gate closes and stays high for `WAIT_CYC` cycles, while `clk_en_o` stays 0.
- R6: `clk_en_o` rises `WAIT_CYC` edges after `div_clr_o` falls. It never rises while `div_clr_o` is high, or on the same edge on which `div_clr_o` falls.
- R7: `div_clr_o` never rises while `clk_en_o` is high, and the two outputs are never high together.
- R8: A start request sampled while a sequence is running has no effect on the output timing.
- R9: If `start_req` is held high continuously, the sequence repeats. `clk_en_o` is high for exactly one cycle per pass and `done_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Ungated fast input clock, the same clock that feeds the gating buffer |
| rst_n | input | 1 | Active-low reset, sampled on `clk_in` |
| start_req | input | 1 | Request to rerun the alignment; acted on only when idle |
| clk_en_o | output | 1 | Synchronous enable for the gating buffer (1 = clock passes) |
| div_clr_o | output | 1 | Common clear to all dividers (1 = held in reset) |
| done_o | output | 1 | Alignment complete and gate open |

## Verification
The alignment run that follows reset is timed with no request applied, which separates automatic start-up from request-driven behaviour. A rerun is driven through a vector table, and that table also injects requests during the gate-closed, clear and release steps. A design that restarts or shifts its timing on those requests is then told apart from one that ignores them. A request held high continuously exposes back-to-back reruns and the one-cycle enable window. A reset applied mid-sequence shows that the block returns to the clear-asserted state from any step.

// File: rtl/clkdiv_align_pkg.sv
// Package: clkdiv_align_pkg
// Holds the sequencer state encoding that the step FSM and the output
// registers share. The order of the states is the order of the steps.
package clkdiv_align_pkg;

    typedef enum logic [1:0] {
        ST_GATE = 2'd0,   // gate closed, clear low, settling
        ST_CLR  = 2'd1,   // gate closed, clear high
        ST_REL  = 2'd2,   // gate closed, clear released
        ST_RUN  = 2'd3    // gate open, idle
    } seq_state_t;

endpackage

// File: rtl/seq_wait_timer.sv
// Module: seq_wait_timer
// A shared down-counter that times every step of the sequence.
// Assumes: reload is pulsed on each state change. expired is high once the
// count reaches zero, which makes each step last WAIT_CYC cycles.
module seq_wait_timer #(
    parameter int WAIT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    output logic expired
);
    localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(WAIT_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Reload on reset or on a state change, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/seq_step_fsm.sv
// Module: seq_step_fsm
// Steps through gate-close, clear, release and run. It leaves a timed step
// only when the timer has expired, and leaves run only on a start request.
// Assumes: reset puts the machine into the clear step.
module seq_step_fsm
    import clkdiv_align_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       expired,
    output seq_state_t state,
    output seq_state_t nxt,
    output logic       changing
);
    seq_state_t state_q;

    // Next-state decode for the four steps.
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_GATE: if (expired) nxt = ST_CLR;
            ST_CLR:  if (expired) nxt = ST_REL;
            ST_REL:  if (expired) nxt = ST_RUN;
            ST_RUN:  if (start)   nxt = ST_GATE;
            default:              nxt = ST_CLR;
        endcase
    end

    // State register; reset lands in the clear step.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CLR;
        else        state_q <= nxt;
    end

    assign state    = state_q;
    assign changing = (nxt != state_q);
endmodule

// File: rtl/seq_out_regs.sv
// Module: seq_out_regs
// Registers the three outputs from the next-state value, so that each port
// is driven by a flip-flop and cannot glitch.
// Assumes: nxt is the state the FSM enters on the same edge.
module seq_out_regs
    import clkdiv_align_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t state,
    input  seq_state_t nxt,
    output logic       en_o,
    output logic       clr_o,
    output logic       done_o
);
    logic en_q, clr_q, done_q;

    // Enable follows the run step, clear follows the clear step, and done
    // follows a second consecutive cycle in run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            clr_q  <= 1'b1;
            done_q <= 1'b0;
        end else begin
            en_q   <= (nxt == ST_RUN);
            clr_q  <= (nxt == ST_CLR);
            done_q <= (state == ST_RUN) && (nxt == ST_RUN);
        end
    end

    assign en_o   = en_q;
    assign clr_o  = clr_q;
    assign done_o = done_q;
endmodule

// File: rtl/clkdiv_align_seq.sv
// Module: clkdiv_align_seq
// Top of the divider alignment sequencer. It closes the clock gate, pulses
// a common clear and reopens the gate, with every step lasting WAIT_CYC cycles.
// Assumes: clk_in is the ungated clock that feeds the gating buffer, and the
// buffer treats clk_en_o as a synchronous enable.
module clkdiv_align_seq #(
    parameter int WAIT_CYC = 4
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic start_req,
    output logic clk_en_o,
    output logic div_clr_o,
    output logic done_o
);
    import clkdiv_align_pkg::*;

    seq_state_t st, st_nxt;
    logic       st_change;
    logic       wait_done;

    seq_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .reload  (st_change),
        .expired (wait_done)
    );

    seq_step_fsm u_fsm (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .start    (start_req),
        .expired  (wait_done),
        .state    (st),
        .nxt      (st_nxt),
        .changing (st_change)
    );

    seq_out_regs u_out (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .state  (st),
        .nxt    (st_nxt),
        .en_o   (clk_en_o),
        .clr_o  (div_clr_o),
        .done_o (done_o)
    );
endmodule

// File: rtl/clkdiv_align_chk.sv
// Module: clkdiv_align_chk
// Checks the ordering rules between enable, clear and done at the ports of
// the sequencer. It is attached to the top module by the bind below.
module clkdiv_align_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic clr,
    input logic done
);
    // R7
    en_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && clr));

    // R7
    clr_rise_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr) |-> $past(!en));

    // R6
    en_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> ($past(!clr) && !clr));

    // R3
    done_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> en);

    // R3
    done_rise_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(en));

    // R4
    en_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> !done);
endmodule

bind clkdiv_align_seq clkdiv_align_chk u_chk (
    .clk   (clk_in),
    .rst_n (rst_n),
    .en    (clk_en_o),
    .clr   (div_clr_o),
    .done  (done_o)
);

// File: tb/sim_clkdiv_align_seq.sv
// Bench for clkdiv_align_seq with the default WAIT_CYC of 4.
module sim_clkdiv_align_seq;
    logic clk_in = 1'b0;
    logic rst_n  = 1'b0;
    logic start_req = 1'b0;
    logic clk_en_o, div_clr_o, done_o;
    int   n_chk = 0;
    int   n_err = 0;

    clkdiv_align_seq #(.WAIT_CYC(4)) u0 (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .start_req (start_req),
        .clk_en_o  (clk_en_o),
        .div_clr_o (div_clr_o),
        .done_o    (done_o)
    );

    always #10 clk_in = ~clk_in;   // 50 MHz

    // Rerun vectors: {start, exp_en, exp_clr, exp_done} per edge, from idle.
    localparam logic [3:0] VEC [16] = '{
        4'b1000, 4'b0000, 4'b1000, 4'b0000,   // R4 gate closed; R8 start at 2
        4'b0010, 4'b1010, 4'b0010, 4'b0010,   // R5 clear held; R8 start at 5
        4'b0000, 4'b0000, 4'b1000, 4'b0000,   // R6 release; R8 start at 10
        4'b0100, 4'b0101, 4'b0101, 4'b0101    // R6 enable, R3 done
    };

    task automatic step(input logic s);
        start_req = s;
        @(posedge clk_in);
        @(negedge clk_in);
    endtask

    task automatic check(input string tag, input logic e, input logic c, input logic d);
        n_chk++;
        if ({clk_en_o, div_clr_o, done_o} !== {e, c, d}) begin
            n_err++;
            $display("FAIL %s en/clr/done got %b%b%b exp %b%b%b",
                     tag, clk_en_o, div_clr_o, done_o, e, c, d);
        end
    endtask

    initial begin
        int en_hi;
        int done_hi;
        @(negedge clk_in);
        // R1: reset state
        step(1'b0); step(1'b1);
        check("R1 reset", 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        // R2: automatic alignment after reset
        for (int i = 1; i <= 9; i++) begin
            step(1'b0);
            if (i < 4)       check("R2 clear held", 1'b0, 1'b1, 1'b0);
            else if (i < 8)  check("R2 released", 1'b0, 1'b0, 1'b0);
            else if (i == 8) check("R2 enable", 1'b1, 1'b0, 1'b0);
            else             check("R3 done", 1'b1, 1'b0, 1'b1);
        end
        // R4 R5 R6 R8: table-driven rerun
        for (int i = 0; i < 16; i++) begin
            step(VEC[i][3]);
            check($sformatf("R4/R5/R6/R8 vec %0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
        end
        // R9: start held high
        en_hi = 0; done_hi = 0;
        for (int i = 0; i < 26; i++) begin
            step(1'b1);
            if (clk_en_o) en_hi++;
            if (done_o)   done_hi++;
        end
        n_chk++;
        if (en_hi != 2 || done_hi != 0) begin
            n_err++;
            $display("FAIL R9 en_hi/done_hi got %0d/%0d exp 2/0", en_hi, done_hi);
        end
        check("R9 last pass enabled", 1'b1, 1'b0, 1'b0);
        step(1'b0);
        check("R3 done after release of start", 1'b1, 1'b0, 1'b1);
        // R1: reset in the middle of a sequence
        step(1'b1); step(1'b0); step(1'b0); step(1'b0); step(1'b0);
        check("R5 mid-clear", 1'b0, 1'b1, 1'b0);
        rst_n = 1'b0;
        step(1'b0);
        check("R1 mid-sequence reset", 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) step(1'b0);
        check("R2 realign after reset", 1'b1, 1'b0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule